// File: doc/BRIEF.md
# Exception Return Frame Unwinder

This block carries out the stack side of a return-from-exception for a processor core. When the core asks for a return, it hands the unwinder the current supervisor stack pointer and pulses `start`. The unwinder then reads the saved frame from memory through a simple read port, one read at a time. When it finishes, it presents the restored program counter, the restored status register and the stack pointer that lies just past the frame. The port returns big-endian data already assembled into a word. The core applies the status register and checks privilege itself; this block only walks the stack.

Two frame layouts are supported, and `compact_mode` selects between them. The classic layout stores a 16-bit status register followed by a 32-bit program counter. When `fmt_word_en` is set, a 16-bit format word follows them. The top nibble of the format word selects how many extra bytes the frame carries. One code marks a throwaway frame: the unwinder steps over it and unwinds again from the next frame up the stack. The compact layout is always 8 bytes long. Its first 32-bit word holds the status register in its low half, plus two bits of stack alignment that the return must restore.

Top module: `xret_unwinder`

## Requirements
- R1: After reset `done`, `mem_req`, `format_error`, `pc_out`, `sr_out` and `sp_out` are all 0.
- R2: In classic mode the reads are issued in this order: a 16-bit read at SP (the status register), a 32-bit read at SP+2 (the program counter) and, when `fmt_word_en` is 1, a 16-bit read at SP+6 (the format word). No other reads are issued.
- R3: The frame code is bits 15:12 of the format word. The resulting stack pointer is SP+8 for code 0, SP+12 for codes 2 and 3, SP+16 for code 4 and SP+60 for code 7.
- R4: Code 1 (throwaway) moves SP to SP+8 and restarts the whole classic unwind from there. The outputs come from the first frame that is not a throwaway frame.
- R5: With `fmt_word_en` at 0, classic mode makes only the status and counter reads, and the result is SP+6.
- R6: In compact mode the block reads a 32-bit word at SP and then a 32-bit program counter at SP+4. `sr_out` is bits 15:0 of the first word. `sp_out` is (SP OR bits 29:28 of the first word, placed in SP bits 1:0) plus 8.
- R7: A frame code other than 0, 1, 2, 3, 4 or 7 adds no extra bytes (the result is SP+8) and sets `format_error` at `done`. The flag holds until the next return completes, and that return clears it unless it also fails.
- R8: `mem_size` 0 is a 16-bit read returning data in `mem_rdata[15:0]`; `mem_size` 1 is a 32-bit read. Once raised, `mem_req` stays high with `mem_addr` and `mem_size` stable until the cycle in which `mem_ack` is seen. At most one read is outstanding.
- R9: `done` is a one-cycle pulse. `pc_out`, `sr_out`, `sp_out` and `format_error` change only in the `done` cycle and hold afterwards.
- R10: While an unwind is in progress, `start`, `sp_in`, `compact_mode` and `fmt_word_en` are ignored; the mode inputs are sampled only with an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an unwind (accepted only when idle) |
| compact_mode | input | 1 | 1 selects the compact 8-byte frame |
| fmt_word_en | input | 1 | Classic mode: frame carries a format word |
| sp_in | input | ADDR_W | Stack pointer at the start of the return |
| done | output | 1 | One-cycle pulse: results valid |
| pc_out | output | 32 | Restored program counter |
| sr_out | output | 16 | Restored status register |
| sp_out | output | ADDR_W | Stack pointer after the frame |
| format_error | output | 1 | Final frame code was not recognised |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | ADDR_W | Read byte address |
| mem_size | output | 1 | 0 = 16-bit, 1 = 32-bit |
| mem_rdata | input | 32 | Read data, big-endian assembled, right-aligned |
| mem_ack | input | 1 | Read completes in this cycle |

## Verification
Several properties are checked on every cycle. The read request must hold its address and size until it is acknowledged, and requests may appear only during an unwind. `done` must last exactly one cycle, and the results must not move outside it. A start that arrives mid-unwind must not disturb the working stack pointer. The address and size of every read, the stack pointer arithmetic for each frame code, throwaway chaining, the compact alignment bits and the error flag can only be shown by the bench. It drives prepared frames in memory with varying acknowledge delays and compares each read and each result against its own model.

// File: rtl/xret_pkg.sv
package xret_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SR,
    ST_PC,
    ST_FMT,
    ST_CW,
    ST_CPC
  } xret_state_t;

  localparam logic SZ_HALF = 1'b0;
  localparam logic SZ_WORD = 1'b1;
  localparam int   SKIP_W  = 6;
  localparam int   WORD_W  = 32;
  localparam int   SR_W    = 16;
endpackage

// File: rtl/xret_fmt_dec.sv
module xret_fmt_dec #(
  parameter int SKIP_W = 6
) (
  input  logic [3:0]        code,
  output logic [SKIP_W-1:0] skip,
  output logic              chain,
  output logic              bad
);
  always_comb begin
    skip  = '0;
    chain = 1'b0;
    bad   = 1'b0;
    case (code)
      4'd0:       skip = '0;
      4'd1:       chain = 1'b1;
      4'd2, 4'd3: skip = SKIP_W'(4);
      4'd4:       skip = SKIP_W'(8);
      4'd7:       skip = SKIP_W'(52);
      default:    bad = 1'b1;
    endcase
  end

  // R7: an unknown code must never add extra bytes
  always_comb begin
    a_r7_bad_no_skip: assert (!(bad && (skip != '0)));
  end
endmodule

// File: rtl/xret_rd_port.sv
module xret_rd_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              issue_size,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_size,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_size <= 1'b0;
      rvalid   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid <= 1'b0;
      if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        rvalid  <= 1'b1;
        rdata_q <= mem_rdata;
      end else if (issue && !mem_req) begin
        mem_req  <= 1'b1;
        mem_addr <= issue_addr;
        mem_size <= issue_size;
      end
    end
  end

  // R8: request held with stable address and size until acknowledged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)));

  // R8: a new read is never issued while one is outstanding
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    issue |-> !mem_req);
endmodule

// File: rtl/xret_unwinder.sv
module xret_unwinder
  import xret_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              compact_mode,
  input  logic              fmt_word_en,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              done,
  output logic [31:0]       pc_out,
  output logic [15:0]       sr_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic              format_error,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_size,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  localparam logic [ADDR_W-1:0] OFS_PC      = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_FMT     = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_CPC     = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] BASE_FRAME  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] SHORT_FRAME = ADDR_W'(6);

  xret_state_t       state;
  logic              pending;
  logic [ADDR_W-1:0] sp_w;
  logic [SR_W-1:0]   sr_w;
  logic [WORD_W-1:0] pc_w;
  logic [SR_W-1:0]   csr_w;
  logic [1:0]        calign_w;
  logic              fe_q;

  logic              issue;
  logic [ADDR_W-1:0] iss_addr;
  logic              iss_size;
  logic              rvalid;
  logic [WORD_W-1:0] rd_data;
  logic [SKIP_W-1:0] skip;
  logic              chain;
  logic              bad;

  xret_rd_port #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_addr (iss_addr),
    .issue_size (iss_size),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .rvalid     (rvalid),
    .rdata_q    (rd_data)
  );

  xret_fmt_dec #(.SKIP_W(SKIP_W)) u_dec (
    .code  (rd_data[15:12]),
    .skip  (skip),
    .chain (chain),
    .bad   (bad)
  );

  assign issue = (state != ST_IDLE) && !pending;

  always_comb begin
    iss_addr = sp_w;
    iss_size = SZ_HALF;
    case (state)
      ST_SR:   begin iss_addr = sp_w;           iss_size = SZ_HALF; end
      ST_PC:   begin iss_addr = sp_w + OFS_PC;  iss_size = SZ_WORD; end
      ST_FMT:  begin iss_addr = sp_w + OFS_FMT; iss_size = SZ_HALF; end
      ST_CW:   begin iss_addr = sp_w;           iss_size = SZ_WORD; end
      ST_CPC:  begin iss_addr = sp_w + OFS_CPC; iss_size = SZ_WORD; end
      default: begin iss_addr = sp_w;           iss_size = SZ_HALF; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      pending      <= 1'b0;
      sp_w         <= '0;
      sr_w         <= '0;
      pc_w         <= '0;
      csr_w        <= '0;
      calign_w     <= '0;
      fe_q         <= 1'b0;
      done         <= 1'b0;
      pc_out       <= '0;
      sr_out       <= '0;
      sp_out       <= '0;
      format_error <= 1'b0;
    end else begin
      done <= 1'b0;
      if (issue)  pending <= 1'b1;
      if (rvalid) pending <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            sp_w  <= sp_in;
            fe_q  <= fmt_word_en;
            state <= compact_mode ? ST_CW : ST_SR;
          end
        end
        ST_SR: begin
          if (rvalid) begin
            sr_w  <= rd_data[SR_W-1:0];
            state <= ST_PC;
          end
        end
        ST_PC: begin
          if (rvalid) begin
            pc_w <= rd_data;
            if (fe_q) begin
              state <= ST_FMT;
            end else begin
              done         <= 1'b1;
              pc_out       <= rd_data;
              sr_out       <= sr_w;
              sp_out       <= sp_w + SHORT_FRAME;
              format_error <= 1'b0;
              state        <= ST_IDLE;
            end
          end
        end
        ST_FMT: begin
          if (rvalid) begin
            if (chain) begin
              sp_w  <= sp_w + BASE_FRAME;
              state <= ST_SR;
            end else begin
              done         <= 1'b1;
              pc_out       <= pc_w;
              sr_out       <= sr_w;
              sp_out       <= sp_w + BASE_FRAME + ADDR_W'(skip);
              format_error <= bad;
              state        <= ST_IDLE;
            end
          end
        end
        ST_CW: begin
          if (rvalid) begin
            csr_w    <= rd_data[SR_W-1:0];
            calign_w <= rd_data[29:28];
            state    <= ST_CPC;
          end
        end
        ST_CPC: begin
          if (rvalid) begin
            done         <= 1'b1;
            pc_out       <= rd_data;
            sr_out       <= csr_w;
            sp_out       <= (sp_w | ADDR_W'(calign_w)) + BASE_FRAME;
            format_error <= 1'b0;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: results move only together with done
  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pc_out) && $stable(sr_out) && $stable(sp_out) && $stable(format_error)));

  // R2: reads are requested only during an unwind
  a_r2_req_when_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (state != ST_IDLE));

  // R10: a start during an unwind leaves the working stack pointer alone
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    ((state != ST_IDLE) && start && !rvalid) |=> $stable(sp_w));
endmodule

// File: tb/xret_unwinder_tb.sv
module xret_unwinder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        compact_mode = 1'b0;
  logic        fmt_word_en = 1'b0;
  logic [31:0] sp_in = '0;
  logic        done;
  logic [31:0] pc_out;
  logic [15:0] sr_out;
  logic [31:0] sp_out;
  logic        format_error;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_size;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  xret_unwinder #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst(rst), .start(start), .compact_mode(compact_mode),
    .fmt_word_en(fmt_word_en), .sp_in(sp_in), .done(done), .pc_out(pc_out),
    .sr_out(sr_out), .sp_out(sp_out), .format_error(format_error),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int nreads = 0;
  int wait_cnt = 0;
  bit monitor_on = 1'b0;
  bit got_done = 1'b0;
  string cur_req = "R1";

  logic [7:0]  mem [logic [31:0]];
  logic [32:0] exp_q [$];
  logic [31:0] exp_pc, exp_sp;
  logic [15:0] exp_sr;
  logic        exp_err;
  logic [31:0] held_pc = '0, held_sp = '0;
  logic [15:0] held_sr = '0;
  logic        held_err = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd8(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {rd8(a), rd8(a + 1)};
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rd16(a), rd16(a + 2)};
  endfunction
  task automatic wr16(input logic [31:0] a, input logic [15:0] d);
    mem[a] = d[15:8]; mem[a + 1] = d[7:0];
  endtask
  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    wr16(a, d[31:16]); wr16(a + 2, d[15:0]);
  endtask
  task automatic classic_frame(input logic [31:0] a, input logic [15:0] sr,
                               input logic [31:0] pc, input logic [15:0] fw);
    wr16(a, sr); wr32(a + 2, pc); wr16(a + 6, fw);
  endtask

  // Behavioural model: the list of reads and the final result
  task automatic model(input bit cmp, input bit fe, input logic [31:0] sp0);
    logic [31:0] sp;
    logic [31:0] cw;
    logic [3:0]  code;
    bit          again;
    sp = sp0;
    exp_q.delete();
    exp_err = 1'b0;
    if (cmp) begin
      exp_q.push_back({1'b1, sp});
      exp_q.push_back({1'b1, sp + 32'd4});
      cw = rd32(sp);
      exp_sr = cw[15:0];
      exp_pc = rd32(sp + 4);
      exp_sp = (sp | {30'd0, cw[29:28]}) + 32'd8;
    end else begin
      again = 1'b1;
      while (again) begin
        again = 1'b0;
        exp_q.push_back({1'b0, sp});
        exp_q.push_back({1'b1, sp + 32'd2});
        exp_sr = rd16(sp);
        exp_pc = rd32(sp + 2);
        if (!fe) begin
          exp_sp = sp + 32'd6;
        end else begin
          exp_q.push_back({1'b0, sp + 32'd6});
          code = rd16(sp + 6) >> 12;
          case (code)
            4'd0: exp_sp = sp + 32'd8;
            4'd1: begin sp = sp + 32'd8; again = 1'b1; end
            4'd2, 4'd3: exp_sp = sp + 32'd12;
            4'd4: exp_sp = sp + 32'd16;
            4'd7: exp_sp = sp + 32'd60;
            default: begin exp_sp = sp + 32'd8; exp_err = 1'b1; end
          endcase
        end
      end
    end
  endtask

  // Memory responder and cycle-by-cycle comparison
  always @(negedge clk) begin
    if (monitor_on) begin
      if (mem_req && !mem_ack) begin
        if (wait_cnt == 0) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected read", mem_addr, 32'h0);
          end else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            chk(mem_addr == e[31:0], cur_req, "read address (R2 order)", mem_addr, e[31:0]);
            chk(mem_size == e[32], "R8", "read size", {31'd0, mem_size}, {31'd0, e[32]});
          end
          mem_rdata = mem_size ? rd32(mem_addr) : {16'h0, rd16(mem_addr)};
          mem_ack = 1'b1;
          nreads++;
          wait_cnt = nreads % 3;
        end else begin
          wait_cnt--;
        end
      end else begin
        mem_ack = 1'b0;
      end
      if (done) begin
        chk(pc_out == exp_pc, cur_req, "pc_out", pc_out, exp_pc);
        chk(sr_out == exp_sr, cur_req, "sr_out", {16'h0, sr_out}, {16'h0, exp_sr});
        chk(sp_out == exp_sp, cur_req, "sp_out", sp_out, exp_sp);
        chk(format_error == exp_err, "R7", "format_error",
            {31'd0, format_error}, {31'd0, exp_err});
        chk(exp_q.size() == 0, "R2", "reads left over", exp_q.size(), 32'd0);
        held_pc = pc_out; held_sr = sr_out; held_sp = sp_out; held_err = format_error;
        got_done = 1'b1;
      end else begin
        chk(pc_out == held_pc && sr_out == held_sr && sp_out == held_sp &&
            format_error == held_err, "R9", "outputs moved without done",
            sp_out, held_sp);
      end
    end
  end

  task automatic run(input string req, input bit cmp, input bit fe,
                     input logic [31:0] sp0, input bit poke);
    int t;
    cur_req = req;
    model(cmp, fe, sp0);
    got_done = 1'b0;
    @(negedge clk);
    sp_in = sp0; compact_mode = cmp; fmt_word_en = fe; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: start and mode changes mid-unwind must be ignored
      repeat (2) @(negedge clk);
      start = 1'b1; sp_in = 32'hDEAD_0000; compact_mode = ~cmp; fmt_word_en = ~fe;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!got_done && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk(got_done, req, "done seen", {31'd0, got_done}, 32'd1);
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    classic_frame(32'h1000, 16'h2704, 32'h00AB_CDEF, 16'h0078);
    classic_frame(32'h2000, 16'h2000, 32'h0000_4000, 16'h2010);
    classic_frame(32'h2100, 16'h2001, 32'h0000_4100, 16'h3024);
    classic_frame(32'h3000, 16'h2302, 32'h1357_9BDF, 16'h4008);
    classic_frame(32'h4000, 16'h2503, 32'h2468_ACE0, 16'h7000);
    classic_frame(32'h5000, 16'h2000, 32'hDEAD_BEEF, 16'h1064);
    classic_frame(32'h5008, 16'h0011, 32'h1122_3344, 16'h0000);
    classic_frame(32'h5100, 16'h2700, 32'hCAFE_0001, 16'h1000);
    classic_frame(32'h5108, 16'h0015, 32'h5566_7788, 16'hA000);
    classic_frame(32'h6000, 16'h0004, 32'h0BAD_F00D, 16'hFFFF);
    wr32(32'h7000, 32'h4078_2004); wr32(32'h7004, 32'h0070_0000);
    wr32(32'h7100, 32'h7000_2700); wr32(32'h7104, 32'h89AB_CDEF);
    classic_frame(32'h8000, 16'h2222, 32'h0000_8888, 16'hA0F0);
    classic_frame(32'h8100, 16'h3333, 32'h0000_9999, 16'h5000);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(done == 1'b0 && mem_req == 1'b0, "R1", "done/mem_req after reset",
        {30'd0, done, mem_req}, 32'd0);
    chk(pc_out == 32'd0 && sr_out == 16'd0 && sp_out == 32'd0 && format_error == 1'b0,
        "R1", "results after reset", pc_out | sp_out, 32'd0);
    monitor_on = 1'b1;

    run("R3", 1'b0, 1'b1, 32'h1000, 1'b0);  // R3 code 0
    run("R3", 1'b0, 1'b1, 32'h2000, 1'b0);  // R3 code 2
    run("R3", 1'b0, 1'b1, 32'h2100, 1'b0);  // R3 code 3
    run("R3", 1'b0, 1'b1, 32'h3000, 1'b0);  // R3 code 4
    run("R3", 1'b0, 1'b1, 32'h4000, 1'b0);  // R3 code 7
    run("R4", 1'b0, 1'b1, 32'h5000, 1'b0);  // R4 throwaway then code 0
    run("R5", 1'b0, 1'b0, 32'h6000, 1'b0);  // R5 no format word
    run("R6", 1'b1, 1'b0, 32'h7000, 1'b0);  // R6 compact, aligned
    run("R6", 1'b1, 1'b1, 32'h7100, 1'b0);  // R6 compact, alignment bits 3
    run("R7", 1'b0, 1'b1, 32'h8000, 1'b0);  // R7 unknown code A
    run("R7", 1'b0, 1'b1, 32'h1000, 1'b0);  // R7 flag clears on good return
    run("R7", 1'b0, 1'b1, 32'h8100, 1'b0);  // R7 unknown code 5
    run("R4", 1'b0, 1'b1, 32'h5100, 1'b0);  // R4 throwaway then unknown code
    run("R10", 1'b0, 1'b1, 32'h3000, 1'b1); // R10 start ignored while busy
    run("R10", 1'b1, 1'b0, 32'h7100, 1'b1); // R10 compact, mode flip ignored
    run("R2", 1'b0, 1'b1, 32'h2000, 1'b0);  // R2 repeat after busy test

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule